// File: doc/BRIEF.md
# Trap Delivery Target and Handler Vector Selector

This block takes a trap that has just been raised and decides where it is delivered. The decision uses the current privilege level, the trap level before the trap, an error-mode flag and a per-trap target code. The block then forms the three sequential fetch addresses of the handler: the first instruction, the one after it, and the one after that. The choice and the addresses are produced combinationally from the inputs.

A copy of the whole result is registered when a one-cycle request strobe is asserted. That copy is stable and valid in the cycle after the strobe, so a pipeline can sample it at a known point. The trap-type table and the saving of processor state are outside the block: the caller supplies the table row for the trap as three 2-bit target codes.

Top module: `trap_vector_sel`

## Requirements
- R1: The current level is hyperprivileged when `hpriv_i` is 1. Otherwise it is privileged when `priv_i` is 1, and otherwise it is user. The block uses the target code for that level from `tgt_codes_i`: bits [1:0] for user, [3:2] for privileged, [5:4] for hyperprivileged. Code 0 means the privileged target. Any other code (1 hyperprivileged, 2 hyperprivileged-from-privileged, 3 reserved) means the hyperprivileged target.
- R2: When `err_mode_i` is 1, or `tl_i` equals MAX_TL-1 (5), the mode is error (2) and `pc_o` is 0xFFF00000A0. This is the error base ORed with vector number 5 shifted left by 5 and masked to 8 bits. This rule overrides every other rule.
- R3: When R2 does not apply and `tl_i` is MAX_TL (6) or larger, the mode is halt (3) and `pc_o`, `npc_o` and `nnpc_o` are all zero.
- R4: When neither R2 nor R3 applies, `tl_i` is greater than MAX_PTL (2) and the target is privileged, the mode is hyperprivileged (1). `pc_o` is `htba_i` with bits [13:0] cleared, ORed with 0x40 (vector number 2).
- R5: When the target is hyperprivileged and R2–R4 do not apply, the mode is hyperprivileged (1). `pc_o` is `htba_i` with bits [13:0] cleared, ORed with (`tt_i` << 5) masked to 14 bits.
- R6: A privileged target whose `tt_i` is 0x180 or above is delivered as in R5. A privileged target with `tt_i` below 0x180 gets mode privileged (0).
- R7: In privileged mode, `pc_o` is `tba_i` with bits [14:0] cleared. Bit 14 is set when `tl_i` is nonzero (the new trap level exceeds 1). The result is ORed with (`tt_i` << 5) masked to 14 bits.
- R8: Outside halt mode, `npc_o` equals `pc_o`+4 and `nnpc_o` equals `pc_o`+8.
- R9: `rec_tt_o` always equals `tt_i`, including when the vector number is replaced (R2, R4).
- R10: After reset `q_valid_o` and all `q_*` outputs are zero. A clock edge with `req_i` high loads `q_*` from the combinational outputs and sets `q_valid_o`. A clock edge with `req_i` low clears `q_valid_o` and leaves the other `q_*` outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Capture strobe for the registered copy |
| tt_i | input | TT_W (9) | Trap type number |
| tl_i | input | TL_W (3) | Trap level before the trap |
| hpriv_i | input | 1 | Hyperprivileged state bit |
| priv_i | input | 1 | Privileged state bit |
| err_mode_i | input | 1 | Processor already in error mode |
| tgt_codes_i | input | 6 | Target codes for the user, privileged and hyperprivileged columns |
| tba_i | input | ADDR_W (64) | Privileged trap base |
| htba_i | input | ADDR_W (64) | Hyperprivileged trap base |
| mode_o | output | 2 | 0 priv, 1 hyper, 2 error, 3 halt |
| rec_tt_o | output | TT_W | Trap type to record |
| pc_o | output | ADDR_W | Handler first fetch address |
| npc_o | output | ADDR_W | Second fetch address |
| nnpc_o | output | ADDR_W | Third fetch address |
| q_valid_o | output | 1 | Registered copy valid |
| q_mode_o | output | 2 | Registered mode |
| q_tt_o | output | TT_W | Registered trap type |
| q_pc_o | output | ADDR_W | Registered PC |
| q_npc_o | output | ADDR_W | Registered NPC |
| q_nnpc_o | output | ADDR_W | Registered next-NPC |

## Verification
The bench sets both privilege bits together, and also sets the privileged bit with columns that disagree. A design that tests the privileged bit first would then read the wrong column and vector through the wrong base. It checks trap numbers 0x17F and 0x180 on a privileged target, where an off-by-one threshold sends one of them to the wrong table. It also checks trap levels 2 and 3, where a wrong watchdog comparison either misses the redirect to vector 2 or applies it early. Trap levels 0 and 1 exercise the bit-14 half of the privileged table. Levels 5, 6 and 7, with and without the error flag, separate error from halt: a design that checks halt before error would halt with the error flag set, and one that leaves the successor adders unmasked would give nonzero addresses in halt.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

   typedef enum logic [1:0] {
      TV_PRIV = 2'd0,
      TV_HYP  = 2'd1,
      TV_ERR  = 2'd2,
      TV_HALT = 2'd3
   } tv_mode_e;

   typedef enum logic [1:0] {
      TGT_PRIV          = 2'd0,
      TGT_HYP           = 2'd1,
      TGT_HYP_FROM_PRIV = 2'd2,
      TGT_RSVD          = 2'd3
   } tv_tgt_e;

   // Column index inside the target-code word
   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_PRIV = 2'd1,
      LVL_HYP  = 2'd2
   } tv_lvl_e;

   localparam int unsigned TV_TGT_W = 2;
   localparam int unsigned TV_NLVL  = 3;
   localparam int unsigned TV_CODES_W = TV_TGT_W * TV_NLVL;

endpackage

// File: rtl/tv_level_decode.sv
module tv_level_decode
   import trapvec_pkg::*;
(
   input  logic                  hpriv_i,
   input  logic                  priv_i,
   input  logic [TV_CODES_W-1:0] codes_i,
   output logic                  to_priv_o
);
   logic [TV_TGT_W-1:0] col [TV_NLVL];
   tv_lvl_e             lvl;

   for (genvar g = 0; g < TV_NLVL; g++) begin : g_col
      assign col[g] = codes_i[g*TV_TGT_W +: TV_TGT_W];
   end

   // R1: hyperprivileged bit dominates the privileged bit
   always_comb begin
      if (hpriv_i)     lvl = LVL_HYP;
      else if (priv_i) lvl = LVL_PRIV;
      else             lvl = LVL_USER;
   end

   assign to_priv_o = (col[lvl] == TGT_PRIV);

endmodule

// File: rtl/tv_route.sv
module tv_route
   import trapvec_pkg::*;
#(
   parameter int unsigned TT_W        = 9,
   parameter int unsigned TL_W        = 3,
   parameter int unsigned MAX_TL      = 6,
   parameter int unsigned MAX_PTL     = 2,
   parameter int unsigned HYP_TT_MIN  = 384,
   parameter int unsigned ERR_VEC_TT  = 5,
   parameter int unsigned WDOG_VEC_TT = 2
)(
   input  logic [TT_W-1:0] tt_i,
   input  logic [TL_W-1:0] tl_i,
   input  logic            err_i,
   input  logic            to_priv_i,
   output tv_mode_e        mode_o,
   output logic [TT_W-1:0] vec_tt_o,
   output logic            tl_gt1_o
);
   localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL - 1);
   localparam logic [TL_W-1:0] TL_HALT = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
   localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

   always_comb begin
      mode_o   = TV_PRIV;
      vec_tt_o = tt_i;
      if (err_i || tl_i == TL_ERR) begin
         mode_o   = TV_ERR;
         vec_tt_o = TT_W'(ERR_VEC_TT);
      end else if (tl_i >= TL_HALT) begin
         mode_o   = TV_HALT;
      end else if (to_priv_i && tl_i > TL_PMAX) begin
         mode_o   = TV_HYP;
         vec_tt_o = TT_W'(WDOG_VEC_TT);
      end else if (!to_priv_i || tt_i >= TT_HMIN) begin
         mode_o   = TV_HYP;
      end
   end

   // New level is tl_i+1; it exceeds 1 exactly when tl_i is nonzero
   assign tl_gt1_o = (tl_i != '0);

endmodule

// File: rtl/tv_vector_gen.sv
module tv_vector_gen
   import trapvec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned TT_W       = 9,
   parameter int unsigned INSN_BYTES = 4,
   parameter int unsigned HYP_ALIGN  = 14,
   parameter int unsigned PRIV_ALIGN = 15,
   parameter int unsigned ERR_OFF_W  = 8,
   parameter int unsigned VEC_SHIFT  = 5,
   parameter logic [ADDR_W-1:0] ERR_BASE = 'hFF_F000_0000
)(
   input  tv_mode_e          mode_i,
   input  logic [TT_W-1:0]   vec_tt_i,
   input  logic              tl_gt1_i,
   input  logic [ADDR_W-1:0] tba_i,
   input  logic [ADDR_W-1:0] htba_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic [ADDR_W-1:0] nnpc_o
);
   localparam int unsigned    NSEQ      = 3;
   localparam logic [ADDR_W-1:0] ONES   = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] HYP_HI  = ONES << HYP_ALIGN;
   localparam logic [ADDR_W-1:0] PRIV_HI = ONES << PRIV_ALIGN;
   localparam logic [ADDR_W-1:0] ERR_LO  = ~(ONES << ERR_OFF_W);
   localparam logic [ADDR_W-1:0] HALF_BIT = ADDR_W'(1) << (PRIV_ALIGN - 1);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] tt_sh, tbl_off, base;
   logic [ADDR_W-1:0] seq [NSEQ];

   assign tt_sh   = ADDR_W'(vec_tt_i) << VEC_SHIFT;
   assign tbl_off = tt_sh & ~HYP_HI;

   always_comb begin
      unique case (mode_i)
         TV_ERR:  base = ERR_BASE | (tt_sh & ERR_LO);
         TV_HYP:  base = (htba_i & HYP_HI) | tbl_off;
         TV_PRIV: base = (tba_i & PRIV_HI) | (tl_gt1_i ? HALF_BIT : '0) | tbl_off;
         default: base = '0;
      endcase
   end

   // Successive fetch addresses, each one instruction on from the last
   assign seq[0] = base;
   for (genvar g = 1; g < NSEQ; g++) begin : g_seq
      assign seq[g] = seq[g-1] + STEP;
   end

   wire halt = (mode_i == TV_HALT);
   assign pc_o   = halt ? '0 : seq[0];
   assign npc_o  = halt ? '0 : seq[1];
   assign nnpc_o = halt ? '0 : seq[2];

endmodule

// File: rtl/tv_out_reg.sv
module tv_out_reg #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned TT_W   = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [1:0]        mode_i,
   input  logic [TT_W-1:0]   tt_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] npc_i,
   input  logic [ADDR_W-1:0] nnpc_i,
   output logic              valid_o,
   output logic [1:0]        mode_o,
   output logic [TT_W-1:0]   tt_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic [ADDR_W-1:0] nnpc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         mode_o  <= '0;
         tt_o    <= '0;
         pc_o    <= '0;
         npc_o   <= '0;
         nnpc_o  <= '0;
      end else begin
         valid_o <= req_i;
         if (req_i) begin
            mode_o <= mode_i;
            tt_o   <= tt_i;
            pc_o   <= pc_i;
            npc_o  <= npc_i;
            nnpc_o <= nnpc_i;
         end
      end
   end
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
   import trapvec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned TT_W       = 9,
   parameter int unsigned TL_W       = 3,
   parameter int unsigned MAX_TL     = 6,
   parameter int unsigned MAX_PTL    = 2,
   parameter int unsigned HYP_TT_MIN = 384,
   parameter int unsigned INSN_BYTES = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic [TT_W-1:0]       tt_i,
   input  logic [TL_W-1:0]       tl_i,
   input  logic                  hpriv_i,
   input  logic                  priv_i,
   input  logic                  err_mode_i,
   input  logic [TV_CODES_W-1:0] tgt_codes_i,
   input  logic [ADDR_W-1:0]     tba_i,
   input  logic [ADDR_W-1:0]     htba_i,
   output logic [1:0]            mode_o,
   output logic [TT_W-1:0]       rec_tt_o,
   output logic [ADDR_W-1:0]     pc_o,
   output logic [ADDR_W-1:0]     npc_o,
   output logic [ADDR_W-1:0]     nnpc_o,
   output logic                  q_valid_o,
   output logic [1:0]            q_mode_o,
   output logic [TT_W-1:0]       q_tt_o,
   output logic [ADDR_W-1:0]     q_pc_o,
   output logic [ADDR_W-1:0]     q_npc_o,
   output logic [ADDR_W-1:0]     q_nnpc_o
);
   localparam int unsigned HYP_ALIGN  = 14;
   localparam int unsigned PRIV_ALIGN = HYP_ALIGN + 1;
   localparam int unsigned VEC_SHIFT  = 5;

   // Elaboration-time parameter checks
   if (ADDR_W < 40) begin : g_bad_addr
      $error("ADDR_W must hold the error base (>= 40 bits)");
   end
   if (MAX_TL >= (1 << TL_W)) begin : g_bad_tl
      $error("MAX_TL must fit in TL_W bits");
   end
   if (MAX_PTL + 1 >= MAX_TL) begin : g_bad_ptl
      $error("MAX_PTL must lie below MAX_TL-1");
   end
   if (TT_W + VEC_SHIFT > HYP_ALIGN) begin : g_bad_tt
      $error("shifted trap type must fit below the table alignment");
   end

   logic            to_priv, tl_gt1;
   tv_mode_e        mode;
   logic [TT_W-1:0] vec_tt;

   tv_level_decode u_lvl (
      .hpriv_i   (hpriv_i),
      .priv_i    (priv_i),
      .codes_i   (tgt_codes_i),
      .to_priv_o (to_priv)
   );

   tv_route #(
      .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL),
      .MAX_PTL(MAX_PTL), .HYP_TT_MIN(HYP_TT_MIN)
   ) u_route (
      .tt_i      (tt_i),
      .tl_i      (tl_i),
      .err_i     (err_mode_i),
      .to_priv_i (to_priv),
      .mode_o    (mode),
      .vec_tt_o  (vec_tt),
      .tl_gt1_o  (tl_gt1)
   );

   tv_vector_gen #(
      .ADDR_W(ADDR_W), .TT_W(TT_W), .INSN_BYTES(INSN_BYTES),
      .HYP_ALIGN(HYP_ALIGN), .PRIV_ALIGN(PRIV_ALIGN), .VEC_SHIFT(VEC_SHIFT)
   ) u_vec (
      .mode_i   (mode),
      .vec_tt_i (vec_tt),
      .tl_gt1_i (tl_gt1),
      .tba_i    (tba_i),
      .htba_i   (htba_i),
      .pc_o     (pc_o),
      .npc_o    (npc_o),
      .nnpc_o   (nnpc_o)
   );

   assign mode_o   = mode;
   assign rec_tt_o = tt_i;

   tv_out_reg #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_i),
      .mode_i  (mode_o),
      .tt_i    (rec_tt_o),
      .pc_i    (pc_o),
      .npc_i   (npc_o),
      .nnpc_i  (nnpc_o),
      .valid_o (q_valid_o),
      .mode_o  (q_mode_o),
      .tt_o    (q_tt_o),
      .pc_o    (q_pc_o),
      .npc_o   (q_npc_o),
      .nnpc_o  (q_nnpc_o)
   );

endmodule

// File: rtl/trap_vector_sel_chk.sv
module trap_vector_sel_chk #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned TT_W    = 9,
   parameter int unsigned TL_W    = 3,
   parameter int unsigned MAX_TL  = 6,
   parameter int unsigned MAX_PTL = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [TT_W-1:0]   tt_i,
   input logic [TL_W-1:0]   tl_i,
   input logic              err_mode_i,
   input logic [1:0]        mode_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o,
   input logic              q_valid_o,
   input logic [1:0]        q_mode_o,
   input logic [ADDR_W-1:0] q_pc_o,
   input logic [ADDR_W-1:0] q_nnpc_o
);
   assert_error_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_mode_i |-> mode_o == 2'd2);

   assert_halt_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> (pc_o == '0 && npc_o == '0));

   assert_wdog_no_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tl_i > TL_W'(MAX_PTL)) |-> mode_o != 2'd0);

   assert_priv_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |-> (pc_o[14] == (tl_i != '0) && tt_i < TT_W'(384)));

   assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid_o && q_mode_o != 2'd3) |-> q_nnpc_o == q_pc_o + ADDR_W'(8));

   assert_valid_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (q_valid_o && q_pc_o == $past(pc_o)));

   assert_valid_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!q_valid_o && $stable(q_pc_o)));

   wire unused_ok = &{1'b0, MAX_TL[0]};
endmodule

bind trap_vector_sel trap_vector_sel_chk #(
   .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W),
   .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .tt_i(tt_i), .tl_i(tl_i),
   .err_mode_i(err_mode_i), .mode_o(mode_o), .pc_o(pc_o), .npc_o(npc_o),
   .q_valid_o(q_valid_o), .q_mode_o(q_mode_o), .q_pc_o(q_pc_o),
   .q_nnpc_o(q_nnpc_o)
);

// File: tb/trap_vector_sel_test.sv
module trap_vector_sel_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        req;
   logic [8:0]  tt;
   logic [2:0]  tl;
   logic        hp, pv, er;
   logic [5:0]  codes;
   logic [63:0] tba, htba;
   logic [1:0]  mode, q_mode;
   logic [8:0]  rtt, q_tt;
   logic [63:0] pc, npc, nnpc, q_pc, q_npc, q_nnpc;
   logic        q_valid;

   trap_vector_sel uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .tt_i(tt), .tl_i(tl),
      .hpriv_i(hp), .priv_i(pv), .err_mode_i(er), .tgt_codes_i(codes),
      .tba_i(tba), .htba_i(htba), .mode_o(mode), .rec_tt_o(rtt),
      .pc_o(pc), .npc_o(npc), .nnpc_o(nnpc), .q_valid_o(q_valid),
      .q_mode_o(q_mode), .q_tt_o(q_tt), .q_pc_o(q_pc), .q_npc_o(q_npc),
      .q_nnpc_o(q_nnpc)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [8:0]  tt;
      logic [2:0]  tl;
      logic        hp, pv, er;
      logic [5:0]  codes;   // {hyp col, priv col, user col}
      logic [1:0]  mode;
      logic [63:0] pc;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{4'd7, 9'h024, 3'd0, 1'b0, 1'b0, 1'b0, 6'b01_00_00, 2'd0, 64'h0000_1234_5678_8480}, // R7 low half
      '{4'd7, 9'h024, 3'd1, 1'b0, 1'b0, 1'b0, 6'b01_00_00, 2'd0, 64'h0000_1234_5678_C480}, // R7 high half
      '{4'd5, 9'h010, 3'd0, 1'b0, 1'b0, 1'b0, 6'b01_01_01, 2'd1, 64'h0000_00AB_CDEF_4200}, // R5
      '{4'd1, 9'h011, 3'd1, 1'b0, 1'b1, 1'b0, 6'b10_10_00, 2'd1, 64'h0000_00AB_CDEF_4220}, // R1 priv column
      '{4'd1, 9'h011, 3'd1, 1'b0, 1'b0, 1'b0, 6'b10_10_00, 2'd0, 64'h0000_1234_5678_C220}, // R1 user column
      '{4'd6, 9'h180, 3'd0, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 2'd1, 64'h0000_00AB_CDEF_7000}, // R6 at threshold
      '{4'd6, 9'h17F, 3'd0, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 2'd0, 64'h0000_1234_5678_AFE0}, // R6 below
      '{4'd4, 9'h020, 3'd3, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 2'd1, 64'h0000_00AB_CDEF_4040}, // R4 redirect
      '{4'd4, 9'h020, 3'd2, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 2'd0, 64'h0000_1234_5678_C400}, // R4 at limit
      '{4'd2, 9'h030, 3'd5, 1'b1, 1'b0, 1'b0, 6'b01_01_01, 2'd2, 64'h0000_00FF_F000_00A0}, // R2 by level
      '{4'd2, 9'h030, 3'd0, 1'b0, 1'b0, 1'b1, 6'b01_01_01, 2'd2, 64'h0000_00FF_F000_00A0}, // R2 by flag
      '{4'd3, 9'h030, 3'd6, 1'b0, 1'b0, 1'b0, 6'b01_01_01, 2'd3, 64'h0},                    // R3
      '{4'd2, 9'h030, 3'd6, 1'b0, 1'b0, 1'b1, 6'b01_01_01, 2'd2, 64'h0000_00FF_F000_00A0}, // R2 over R3
      '{4'd1, 9'h040, 3'd1, 1'b1, 1'b1, 1'b0, 6'b01_00_00, 2'd1, 64'h0000_00AB_CDEF_4800}, // R1 hyp dominates
      '{4'd1, 9'h040, 3'd1, 1'b0, 1'b1, 1'b0, 6'b01_10_00, 2'd1, 64'h0000_00AB_CDEF_4800}, // R1
      '{4'd1, 9'h040, 3'd1, 1'b0, 1'b0, 1'b0, 6'b01_10_00, 2'd0, 64'h0000_1234_5678_C800}, // R1
      '{4'd3, 9'h007, 3'd7, 1'b0, 1'b0, 1'b0, 6'b01_01_01, 2'd3, 64'h0}                     // R3 above max
   };

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic check(input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      req = 0; tt = '0; tl = '0; hp = 0; pv = 0; er = 0; codes = '0;
      tba  = 64'h0000_1234_5678_9ABC;
      htba = 64'h0000_00AB_CDEF_7777;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "reset q_valid", 64'(q_valid), 64'd0);
      check("R10", "reset q_pc", q_pc, 64'd0);
      check("R10", "reset q_mode", 64'(q_mode), 64'd0);
      rst_n = 1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string rq;
         logic [63:0] e_npc, e_nnpc;
         rq = $sformatf("R%0d", VECS[i].rq);
         tt = VECS[i].tt; tl = VECS[i].tl; hp = VECS[i].hp;
         pv = VECS[i].pv; er = VECS[i].er; codes = VECS[i].codes;
         req = 1;
         e_npc  = (VECS[i].mode == 2'd3) ? 64'd0 : VECS[i].pc + 64'd4;
         e_nnpc = (VECS[i].mode == 2'd3) ? 64'd0 : VECS[i].pc + 64'd8;
         #1;
         check(rq, "mode", 64'(mode), 64'(VECS[i].mode));
         check(rq, "pc", pc, VECS[i].pc);
         check("R8", "npc", npc, e_npc);
         check("R8", "nnpc", nnpc, e_nnpc);
         check("R9", "rec_tt", 64'(rtt), 64'(VECS[i].tt));
         @(negedge clk);
         req = 0;
         // R10 capture after strobe
         check("R10", "q_valid", 64'(q_valid), 64'd1);
         check("R10", "q_pc", q_pc, VECS[i].pc);
         check("R10", "q_nnpc", q_nnpc, e_nnpc);
         check("R10", "q_tt", 64'(q_tt), 64'(VECS[i].tt));
      end

      // R10 hold: new inputs without strobe leave the copy alone
      tt = 9'h024; tl = 3'd0; hp = 0; pv = 0; er = 0; codes = 6'b01_00_00;
      @(negedge clk);
      check("R10", "hold q_valid", 64'(q_valid), 64'd0);
      check("R10", "hold q_pc", q_pc, 64'h0);
      check("R10", "hold q_mode", 64'(q_mode), 64'd3);
      check("R10", "hold q_npc", q_npc, 64'h0);

      // R9 with watchdog vector swap: recorded type stays the input
      tt = 9'h0C5; tl = 3'd4; codes = 6'b00_00_00;
      #1;
      check("R9", "rec_tt wdog", 64'(rtt), 64'h0C5);
      check("R4", "wdog pc", pc, 64'h0000_00AB_CDEF_4040);

      done = 1;
      finish_run();
   end
endmodule